// File: doc/BRIEF.md
# Program-to-Data Memory Copy Arbiter

This block sits between a statically scheduled wide-instruction core and its two memory buses. In everyday operation it is transparent: the core's data loads and stores go straight to data memory, and the core's instruction fetch address goes straight to program memory. Its one job is to let a start-up repair routine read instruction words out of program memory as data, so that the routine can move operations between slots.

The routine does this with an ordinary load and store. A load from a reserved trigger address never reaches data memory; it arms a one-shot copy mode. The next store is then reinterpreted. Its write data is taken as a program memory address, and its address is taken as the destination in data memory. The arbiter borrows the program memory bus for that fetch and asserts a fetch-hold output for two cycles. It then writes the fetched instruction word into data memory. When the instruction is wider than a data word, the writes land at consecutive addresses, least significant part first. The routine must schedule no-op bundles behind the copying store so that its own instruction stream stays aligned while the bus is borrowed and the writes drain.

Top module: `pm_copy_arbiter`

## Requirements
- R1: After reset the arbiter is in pass-through mode: fetchHold is 0, pmAddr equals coreFetchAddr, and no data memory request is issued while the core issues none.
- R2: Outside copy mode, every core load or store to an address other than the trigger address appears on the data memory port in the same cycle with unchanged request, write-enable, address and write data, and dmRdata is returned on coreDRdata. A store to the trigger address is also an ordinary store.
- R3: A core load from the trigger address (default 0xFFFF) issues no data memory request and arms copy mode.
- R4: While armed, loads to other addresses pass through unchanged, and further trigger loads are suppressed; neither one cancels the armed state.
- R5: The first store while armed issues no data memory request. In that same cycle pmAddr carries the low PA bits of the store's write data.
- R6: fetchHold is 1 in the copying store's cycle and in the cycle after it, and 0 in every other cycle.
- R7: Starting two cycles after the copying store, the arbiter writes the fetched instruction word over WORDS consecutive cycles. Write k goes to the store address plus k, with data bits [k*DW +: DW] of the word, so the least significant part is written first.
- R8: Copy mode is one-shot. Once the last word is written, the next store passes to data memory unchanged.
- R9: When fetchHold is 0, pmAddr equals coreFetchAddr, and fetchInstr always carries pmRdata.
- R10: During the copy write cycles, any core data request is ignored; the data memory port carries only the arbiter's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreFetchAddr | input | PA | Core instruction fetch address |
| fetchInstr | output | IW | Instruction word returned to the core |
| fetchHold | output | 1 | Program bus borrowed; core must not consume fetch data |
| coreDReq | input | 1 | Core data access request |
| coreDWe | input | 1 | Core data access is a store |
| coreDAddr | input | DA | Core data address |
| coreDWdata | input | DW | Core store data |
| coreDRdata | output | DW | Load data returned to the core |
| pmAddr | output | PA | Program memory address |
| pmRdata | input | IW | Program memory read data, one cycle after the address |
| dmReq | output | 1 | Data memory request |
| dmWe | output | 1 | Data memory write enable |
| dmAddr | output | DA | Data memory address |
| dmWdata | output | DW | Data memory write data |
| dmRdata | input | DW | Data memory read data |

## Verification
The properties rely on the routine keeping its part of the bargain. The core issues no data request in the capture cycle or in the write cycles that follow a copying store, and program memory returns its data exactly one cycle after the address. The stimulus follows these rules in every copy sequence except one. That sequence drives a deliberate store during a write cycle to show at the ports that it is ignored. The bench's program memory model is a registered lookup whose word is a function of the address, so each fetched value can be predicted.

// File: rtl/pmcopy_pkg.sv
package pmcopy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_WRITE   = 2'd3
  } copyState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic copySrc;   // drive pmAddr from store data
    logic capDest;   // latch destination address
    logic capInstr;  // latch fetched instruction word
    logic wrStep;    // issue one copy write and advance word index
    logic blockCore; // keep core data request off the memory port
    logic hold;      // fetch-hold toward the core
  } ctlStrobe_t;

endpackage

// File: rtl/pmcopy_ctrl.sv
module pmcopy_ctrl
  import pmcopy_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       coreDReq,
  input  logic       coreDWe,
  input  logic       isTrig,
  input  logic       lastWord,
  output ctlStrobe_t strb
);

  copyState_t state, stateNext;
  logic isLoad, isStore;

  assign isLoad  = coreDReq && !coreDWe;
  assign isStore = coreDReq && coreDWe;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (isLoad && isTrig) begin
          strb.blockCore = 1'b1;
          stateNext      = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (isLoad && isTrig) begin
          strb.blockCore = 1'b1;
        end else if (isStore) begin
          strb.copySrc   = 1'b1;
          strb.capDest   = 1'b1;
          strb.blockCore = 1'b1;
          strb.hold      = 1'b1;
          stateNext      = ST_CAPTURE;
        end
      end
      ST_CAPTURE: begin
        strb.capInstr  = 1'b1;
        strb.blockCore = 1'b1;
        strb.hold      = 1'b1;
        stateNext      = ST_WRITE;
      end
      ST_WRITE: begin
        strb.wrStep    = 1'b1;
        strb.blockCore = 1'b1;
        if (lastWord) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pmcopy_dpath.sv
module pmcopy_dpath
  import pmcopy_pkg::*;
#(
  parameter int DW = 16,
  parameter int DA = 16,
  parameter int PA = 12,
  parameter int IW = 32,
  parameter logic [DA-1:0] TRIG_ADDR = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strb,
  input  logic [PA-1:0] coreFetchAddr,
  output logic [IW-1:0] fetchInstr,
  input  logic          coreDReq,
  input  logic          coreDWe,
  input  logic [DA-1:0] coreDAddr,
  input  logic [DW-1:0] coreDWdata,
  output logic [DW-1:0] coreDRdata,
  output logic [PA-1:0] pmAddr,
  input  logic [IW-1:0] pmRdata,
  output logic          dmReq,
  output logic          dmWe,
  output logic [DA-1:0] dmAddr,
  output logic [DW-1:0] dmWdata,
  input  logic [DW-1:0] dmRdata,
  output logic          isTrig,
  output logic          lastWord
);

  localparam int WORDS = (IW + DW - 1) / DW;
  localparam int IDXW  = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int PADW  = WORDS * DW;

  logic [DA-1:0]   destReg;
  logic [IW-1:0]   instrReg;
  logic [IDXW-1:0] wordIdx;
  logic [PADW-1:0] instrPad;
  logic [DW-1:0]   wordArr [WORDS];

  assign instrPad = PADW'(instrReg);

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : gSplit
      assign wordArr[g] = instrPad[g*DW +: DW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destReg  <= '0;
      instrReg <= '0;
      wordIdx  <= '0;
    end else begin
      if (strb.capDest)  destReg <= coreDAddr;
      if (strb.capInstr) begin
        instrReg <= pmRdata;
        wordIdx  <= '0;
      end else if (strb.wrStep) begin
        wordIdx  <= lastWord ? '0 : wordIdx + 1'b1;
      end
    end
  end

  assign isTrig   = (coreDAddr == TRIG_ADDR);
  assign lastWord = (wordIdx == IDXW'(WORDS - 1));

  // Program bus sharing
  assign pmAddr     = strb.copySrc ? coreDWdata[PA-1:0] : coreFetchAddr;
  assign fetchInstr = pmRdata;

  // Data bus sharing
  always_comb begin
    if (strb.wrStep) begin
      dmReq   = 1'b1;
      dmWe    = 1'b1;
      dmAddr  = destReg + DA'(wordIdx);
      dmWdata = wordArr[wordIdx];
    end else if (strb.blockCore) begin
      dmReq   = 1'b0;
      dmWe    = 1'b0;
      dmAddr  = coreDAddr;
      dmWdata = coreDWdata;
    end else begin
      dmReq   = coreDReq;
      dmWe    = coreDWe;
      dmAddr  = coreDAddr;
      dmWdata = coreDWdata;
    end
  end

  assign coreDRdata = dmRdata;

endmodule

// File: rtl/pm_copy_arbiter.sv
module pm_copy_arbiter
  import pmcopy_pkg::*;
#(
  parameter int DW = 16,
  parameter int DA = 16,
  parameter int PA = 12,
  parameter int IW = 32,
  parameter logic [DA-1:0] TRIG_ADDR = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [PA-1:0] coreFetchAddr,
  output logic [IW-1:0] fetchInstr,
  output logic          fetchHold,
  input  logic          coreDReq,
  input  logic          coreDWe,
  input  logic [DA-1:0] coreDAddr,
  input  logic [DW-1:0] coreDWdata,
  output logic [DW-1:0] coreDRdata,
  output logic [PA-1:0] pmAddr,
  input  logic [IW-1:0] pmRdata,
  output logic          dmReq,
  output logic          dmWe,
  output logic [DA-1:0] dmAddr,
  output logic [DW-1:0] dmWdata,
  input  logic [DW-1:0] dmRdata
);

  ctlStrobe_t strb;
  logic isTrig, lastWord;

  pmcopy_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .coreDReq (coreDReq),
    .coreDWe  (coreDWe),
    .isTrig   (isTrig),
    .lastWord (lastWord),
    .strb     (strb)
  );

  pmcopy_dpath #(
    .DW(DW), .DA(DA), .PA(PA), .IW(IW), .TRIG_ADDR(TRIG_ADDR)
  ) uDpath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .coreFetchAddr (coreFetchAddr),
    .fetchInstr    (fetchInstr),
    .coreDReq      (coreDReq),
    .coreDWe       (coreDWe),
    .coreDAddr     (coreDAddr),
    .coreDWdata    (coreDWdata),
    .coreDRdata    (coreDRdata),
    .pmAddr        (pmAddr),
    .pmRdata       (pmRdata),
    .dmReq         (dmReq),
    .dmWe          (dmWe),
    .dmAddr        (dmAddr),
    .dmWdata       (dmWdata),
    .dmRdata       (dmRdata),
    .isTrig        (isTrig),
    .lastWord      (lastWord)
  );

  assign fetchHold = strb.hold;

endmodule

// File: rtl/pmcopy_checker.sv
module pmcopy_checker #(
  parameter int DW = 16,
  parameter int DA = 16,
  parameter int PA = 12,
  parameter logic [DA-1:0] TRIG_ADDR = '1
) (
  input logic          clk,
  input logic          rstN,
  input logic          fetchHold,
  input logic [PA-1:0] coreFetchAddr,
  input logic          coreDReq,
  input logic          coreDWe,
  input logic [DA-1:0] coreDAddr,
  input logic [DW-1:0] coreDWdata,
  input logic [PA-1:0] pmAddr,
  input logic          dmReq,
  input logic          dmWe
);

  AST_TRIG_LOAD_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (coreDReq && !coreDWe && coreDAddr == TRIG_ADDR) |-> !(dmReq && !dmWe)); // R3

  AST_FETCH_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !fetchHold |-> (pmAddr == coreFetchAddr)); // R9

  AST_HOLD_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchHold) |=> fetchHold); // R6

  AST_HOLD_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (fetchHold && $past(fetchHold)) |=> !fetchHold); // R6

  AST_COPY_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchHold) |-> (pmAddr == coreDWdata[PA-1:0] && !dmReq)); // R5

  AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (fetchHold && $past(fetchHold)) |=> (dmReq && dmWe)); // R7

endmodule

bind pm_copy_arbiter pmcopy_checker #(
  .DW(DW), .DA(DA), .PA(PA), .TRIG_ADDR(TRIG_ADDR)
) uChecker (
  .clk           (clk),
  .rstN          (rstN),
  .fetchHold     (fetchHold),
  .coreFetchAddr (coreFetchAddr),
  .coreDReq      (coreDReq),
  .coreDWe       (coreDWe),
  .coreDAddr     (coreDAddr),
  .coreDWdata    (coreDWdata),
  .pmAddr        (pmAddr),
  .dmReq         (dmReq),
  .dmWe          (dmWe)
);

// File: tb/pm_copy_arbiter_test.sv
module pm_copy_arbiter_test;

  localparam int DW = 16;
  localparam int DA = 16;
  localparam int PA = 12;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [PA-1:0] coreFetchAddr = '0;
  logic [IW-1:0] fetchInstr;
  logic          fetchHold;
  logic          coreDReq = 1'b0;
  logic          coreDWe = 1'b0;
  logic [DA-1:0] coreDAddr = '0;
  logic [DW-1:0] coreDWdata = '0;
  logic [DW-1:0] coreDRdata;
  logic [PA-1:0] pmAddr;
  logic [IW-1:0] pmRdata = '0;
  logic          dmReq;
  logic          dmWe;
  logic [DA-1:0] dmAddr;
  logic [DW-1:0] dmWdata;
  logic [DW-1:0] dmRdata = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pm_copy_arbiter uut (.*);

  function automatic logic [IW-1:0] pat(input logic [PA-1:0] a);
    return {4'hC, a, 4'h3, ~a};
  endfunction

  // Program memory model: one-cycle registered read
  always @(posedge clk) pmRdata <= pat(pmAddr);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic req, input logic we, input logic [DA-1:0] a, input logic [DW-1:0] d);
    coreDReq = req; coreDWe = we; coreDAddr = a; coreDWdata = d;
  endtask

  task automatic nextCycle();
    @(negedge clk);
  endtask

  // Pass-through vectors: req, we, addr, wdata, rdata
  typedef struct packed {
    logic          req;
    logic          we;
    logic [DA-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 16'h0010, 16'h0000, 16'h1234},
    '{1'b1, 1'b1, 16'h0020, 16'hBEEF, 16'h0000},
    '{1'b1, 1'b0, 16'hFFFE, 16'h0000, 16'h5A5A},
    '{1'b1, 1'b1, 16'hFFFF, 16'h0777, 16'h0000},
    '{1'b0, 1'b0, 16'h0300, 16'h1111, 16'h2222},
    '{1'b1, 1'b1, 16'h8000, 16'h00FF, 16'hCAFE}
  };

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [IW-1:0] w;
    coreFetchAddr = 12'h055;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(fetchHold == 1'b0, "R1 hold", fetchHold, 0);
    chk(pmAddr == 12'h055, "R1 pmAddr", pmAddr, 12'h055);
    chk(dmReq == 1'b0, "R1 dmReq", dmReq, 0);

    // R2 pass-through table
    foreach (VECS[i]) begin
      nextCycle();
      drive(VECS[i].req, VECS[i].we, VECS[i].addr, VECS[i].wdata);
      dmRdata = VECS[i].rdata;
      coreFetchAddr = 12'h100 + 12'(i);
      #1;
      chk(dmReq == VECS[i].req && dmWe == VECS[i].we, "R2 req/we", {dmReq, dmWe}, {VECS[i].req, VECS[i].we});
      chk(dmAddr == VECS[i].addr && dmWdata == VECS[i].wdata, "R2 addr/data", {dmAddr, dmWdata}, {VECS[i].addr, VECS[i].wdata});
      chk(coreDRdata == VECS[i].rdata, "R2 rdata", coreDRdata, VECS[i].rdata);
      chk(pmAddr == coreFetchAddr && fetchHold == 1'b0, "R9 fetch pass", pmAddr, coreFetchAddr);
    end

    // R3 trigger load
    nextCycle(); drive(1, 0, 16'hFFFF, 0); #1;
    chk(dmReq == 1'b0, "R3 trigger suppressed", dmReq, 0);
    // R4 armed: other load passes, repeated trigger suppressed
    nextCycle(); drive(1, 0, 16'h0042, 0); #1;
    chk(dmReq == 1'b1 && dmWe == 1'b0 && dmAddr == 16'h0042, "R4 armed load passes", {dmReq, dmAddr}, {1'b1, 16'h0042});
    nextCycle(); drive(1, 0, 16'hFFFF, 0); #1;
    chk(dmReq == 1'b0, "R4 repeat trigger", dmReq, 0);
    chk(fetchHold == 1'b0, "R6 hold low while armed", fetchHold, 0);

    // R5 copying store
    coreFetchAddr = 12'h200;
    nextCycle(); drive(1, 1, 16'h0040, 16'h0123); #1;
    chk(pmAddr == 12'h123, "R5 pmAddr from data", pmAddr, 12'h123);
    chk(dmReq == 1'b0, "R5 store suppressed", dmReq, 0);
    chk(fetchHold == 1'b1, "R6 hold cycle 1", fetchHold, 1);
    nextCycle(); drive(0, 0, 0, 0); #1;
    chk(fetchHold == 1'b1, "R6 hold cycle 2", fetchHold, 1);
    chk(fetchInstr == pat(12'h123), "R9 fetchInstr carries pm data", fetchInstr, pat(12'h123));
    w = pat(12'h123);
    // R7 writes, R10 core request ignored in first write
    nextCycle(); drive(1, 1, 16'h0999, 16'hDEAD); #1;
    chk(fetchHold == 1'b0, "R6 hold released", fetchHold, 0);
    chk(dmReq && dmWe && dmAddr == 16'h0040, "R7 word0 addr", dmAddr, 16'h0040);
    chk(dmWdata == w[15:0], "R7 word0 data", dmWdata, w[15:0]);
    chk(dmWdata != 16'hDEAD && dmAddr != 16'h0999, "R10 core store ignored", dmAddr, 16'h0040);
    nextCycle(); drive(0, 0, 0, 0); #1;
    chk(dmReq && dmWe && dmAddr == 16'h0041, "R7 word1 addr", dmAddr, 16'h0041);
    chk(dmWdata == w[31:16], "R7 word1 data", dmWdata, w[31:16]);

    // R8 one-shot: next store passes
    nextCycle(); drive(1, 1, 16'h0050, 16'h0456); #1;
    chk(dmReq && dmWe && dmAddr == 16'h0050 && dmWdata == 16'h0456, "R8 store passes", {dmAddr, dmWdata}, {16'h0050, 16'h0456});
    chk(fetchHold == 1'b0 && pmAddr == 12'h200, "R8 no borrow", pmAddr, 12'h200);

    // Second copy with different source, from idle
    nextCycle(); drive(1, 0, 16'hFFFF, 0);
    nextCycle(); drive(1, 1, 16'h1000, 16'h0ABC); #1;
    chk(pmAddr == 12'hABC, "R5 second copy source", pmAddr, 12'hABC);
    nextCycle(); drive(0, 0, 0, 0);
    w = pat(12'hABC);
    nextCycle(); #1;
    chk(dmAddr == 16'h1000 && dmWdata == w[15:0], "R7 second word0", dmWdata, w[15:0]);
    nextCycle(); #1;
    chk(dmAddr == 16'h1001 && dmWdata == w[31:16], "R7 second word1", dmWdata, w[31:16]);
    nextCycle(); #1;
    chk(dmReq == 1'b0 && fetchHold == 1'b0, "R8 back to idle", dmReq, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule